// File: doc/BRIEF.md
# Masked Level Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt request lines from devices on a local bus and presents them to the rest of the chip as a single interrupt output. A source register samples the request levels on every clock. A software-writable enable mask selects which lines may reach the output. The output stays high for as long as at least one enabled line is requesting.

Software reaches the block through a small 16-bit register port with two locations. Reading the identifier location does not return a bitmap. It returns a code that names one pending line: the line index plus one, shifted left by two bit positions. The lowest-numbered pending line wins, and a read returns zero when nothing is pending. The mask location reads and writes the enable mask. After reset, only line 4 is enabled. Interrupt vectoring and edge detection belong to other blocks.

Top module: `irq_aggregator`

## Requirements
- R1: Bit k of the source register follows the level of `irq_in[k]`. A change on the input is captured at the next rising clock edge.
- R2: `irq_out` is high exactly when the bitwise AND of the source register and the enable mask is non-zero. It follows a change on an input, or a mask write, one clock edge later.
- R3: A read at byte offset 0x0 returns `(k+1) << 2`, where k is the lowest-indexed line that is both requesting and enabled. Bits [1:0] of the code are always zero, and line 15 reads as 0x40.
- R4: A read at offset 0x0 returns 0 when no line is both requesting and enabled. Lines that request while disabled do not affect the code or `irq_out`.
- R5: Reset forces the enable mask to 0x0010, so only line 4 is enabled. Reset also forces `irq_out` low and `reg_rdata` to zero.
- R6: A write at byte offset 0x2 loads all 16 bits of the enable mask. A read at offset 0x2 returns the mask. The mask changes only on such a write.
- R7: A read at any offset other than 0x0 or 0x2 returns zero. A write there leaves the mask unchanged.
- R8: `reg_rdata` is updated at the clock edge that accepts a read request (`reg_en` high, `reg_we` low). It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Level interrupt request lines, bit k is line k |
| reg_en | input | 1 | Register access request for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
Every result is due one rising edge after its stimulus:
- a new request level reaches `irq_out` after one edge;
- a mask write reaches `irq_out` after one edge;
- a read request appears on `reg_rdata` after one edge.

The bench changes inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. For latency, it also samples `irq_out` just after the input change, before that edge, to confirm the old value is still present. For the hold rule, it changes the request lines without issuing a read and checks that `reg_rdata` keeps its previous value.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Decoded kind of register access in the current cycle
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_ID,
        ACC_RD_MASK,
        ACC_WR_MASK,
        ACC_WR_ID,
        ACC_OTHER
    } acc_kind_e;

endpackage

// File: rtl/irq_src_sampler.sv
module irq_src_sampler #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] src_q
);

    // One flop per request line; the level is taken as is, with no edge logic
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= lines_in;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int              NUM_LINES = 16,
    parameter logic [15:0]     MASK_RST  = 16'h0010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mask_q
);

    localparam logic [NUM_LINES-1:0] RST_VAL = MASK_RST[NUM_LINES-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= RST_VAL;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

    // R6: without a write strobe the mask keeps its value
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/irq_lowest_encoder.sv
module irq_lowest_encoder #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES + 1),
    parameter int CODE_W    = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend,
    output logic [CODE_W-1:0]    code
);

    logic [NUM_LINES-1:0] seen;   // seen[i]: some line below i is pending
    logic [NUM_LINES-1:0] grant;  // one-hot lowest pending line

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign grant[i] = pend[i] & ~seen[i];
        if (i < NUM_LINES - 1) begin : g_chain
            assign seen[i+1] = seen[i] | pend[i];
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (grant[i]) begin
                code = code | {IDX_W'(i + 1), 2'b00};
            end
        end
    end

    // R3: at most one line is selected, and one is selected whenever any is pending
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (code != '0));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int          NUM_LINES = 16,
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 4,
    parameter logic [15:0] MASK_RST  = 16'h0010,
    parameter int          ID_OFS    = 0,
    parameter int          MASK_OFS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out
);

    import irq_agg_pkg::*;

    localparam int IDX_W  = $clog2(NUM_LINES + 1);
    localparam int CODE_W = IDX_W + 2;
    localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic [NUM_LINES-1:0] src_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend;
    logic [CODE_W-1:0]    code;
    logic [DATA_W-1:0]    rdata_q;
    acc_kind_e            acc;

    irq_src_sampler #(.NUM_LINES(NUM_LINES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in),
        .src_q    (src_q)
    );

    irq_mask_reg #(.NUM_LINES(NUM_LINES), .MASK_RST(MASK_RST)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc == ACC_WR_MASK),
        .wr_data (reg_wdata[NUM_LINES-1:0]),
        .mask_q  (mask_q)
    );

    assign pend = src_q & mask_q;

    irq_lowest_encoder #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .code  (code)
    );

    // Access decode
    always_comb begin
        if (!reg_en) begin
            acc = ACC_NONE;
        end else if (reg_addr == ID_A) begin
            acc = reg_we ? ACC_WR_ID : ACC_RD_ID;
        end else if (reg_addr == MASK_A) begin
            acc = reg_we ? ACC_WR_MASK : ACC_RD_MASK;
        end else begin
            acc = ACC_OTHER;
        end
    end

    // Read data register: loads on reads only, holds otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (acc)
                ACC_RD_ID:   rdata_q <= DATA_W'(code);
                ACC_RD_MASK: rdata_q <= DATA_W'(mask_q);
                ACC_OTHER:   if (!reg_we) rdata_q <= '0;
                ACC_NONE, ACC_WR_MASK, ACC_WR_ID: ;
                default:     ;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_out   = |pend;

    // R2: with every request line low, the output is low one edge later
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |=> !irq_out);
    // R2: clearing the mask silences the output one edge later
    p_mask_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == MASK_A && reg_wdata == '0) |=> !irq_out);
    // R3: identifier codes always have the two low bits clear
    p_code_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr == ID_A) |=> (reg_rdata[1:0] == 2'b00));
    // R7: reads at unused offsets return zero
    p_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr != ID_A && reg_addr != MASK_A) |=> (reg_rdata == '0));
    // R8: read data holds while no read is issued
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> $stable(reg_rdata));

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    // {request lines, mask, expected identifier code}
    localparam logic [47:0] VECS [8] = '{
        {16'h0010, 16'h0010, 16'h0014},
        {16'h0001, 16'h0010, 16'h0000},
        {16'h0003, 16'hFFFF, 16'h0004},
        {16'h8000, 16'h8000, 16'h0040},
        {16'hF0F0, 16'h0F00, 16'h0000},
        {16'hF0F0, 16'hFF00, 16'h0034},
        {16'hFFFF, 16'hFFFE, 16'h0008},
        {16'h0400, 16'h0400, 16'h002C}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        exp_irq;
        repeat (3) @(negedge clk);
        // R5: reset state
        chk("R5 irq_out in reset", {15'b0, irq_out}, 16'h0);
        chk("R5 rdata in reset", reg_rdata, 16'h0);
        rst_n = 1'b1;
        bus_rd(4'h2, d);
        chk("R5 mask reset value", d, 16'h0010);
        // R5: default mask passes line 4 only; R2 latency
        @(negedge clk);
        irq_in = 16'h0020;
        @(negedge clk);
        chk("R4 disabled line 5 ignored", {15'b0, irq_out}, 16'h0);
        irq_in = 16'h0010;
        #1 chk("R2 output not yet updated", {15'b0, irq_out}, 16'h0);
        @(negedge clk);
        chk("R1 R5 line 4 enabled after reset", {15'b0, irq_out}, 16'h1);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            bus_wr(4'h2, VECS[v][31:16]);
            @(negedge clk);
            irq_in = VECS[v][47:32];
            exp_irq = |(VECS[v][47:32] & VECS[v][31:16]);
            @(negedge clk);
            chk("R2 irq_out vector", {15'b0, irq_out}, {15'b0, exp_irq});
            bus_rd(4'h0, d);
            chk("R3 R4 identifier vector", d, VECS[v][15:0]);
            bus_rd(4'h2, d);
            chk("R6 mask readback vector", d, VECS[v][31:16]);
        end

        // R2: mask write takes effect one edge later
        irq_in = 16'h0100;
        bus_wr(4'h2, 16'h0000);
        chk("R2 mask clear drops output", {15'b0, irq_out}, 16'h0);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 4'h2; reg_wdata = 16'h0100;
        #1 chk("R2 before write edge", {15'b0, irq_out}, 16'h0);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        chk("R2 after write edge", {15'b0, irq_out}, 16'h1);

        // R7: unused offsets
        bus_wr(4'h4, 16'hFFFF);
        bus_wr(4'h0, 16'hFFFF);
        bus_rd(4'h2, d);
        chk("R7 mask unchanged by other writes", d, 16'h0100);
        bus_rd(4'h6, d);
        chk("R7 other offset reads zero", d, 16'h0000);

        // R8: rdata holds without a read
        bus_rd(4'h0, d);
        chk("R3 line 8 code", d, 16'h0024);
        @(negedge clk);
        irq_in = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R8 rdata holds", reg_rdata, 16'h0024);
        chk("R2 output drops with lines", {15'b0, irq_out}, 16'h0);
        bus_rd(4'h0, d);
        chk("R4 nothing pending reads zero", d, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule